// File: doc/BRIEF.md
# Bus-to-DMA Address Window Translator

This block turns an address seen on the I/O bus into a system DMA address. It holds no registers of its own for the windows: the enclosing register file presents, for each window, a base word, a size-mask word and a translated base on flat configuration ports. The windows are evaluated in parallel, and the lowest-numbered enabled window that matches decides the translation.

A window translates in one of two ways. In direct mode the low part of the bus address is kept and the upper part comes from the translated base. In scatter-gather mode the block forms the address of a 64-bit page-table entry, reads that entry through a memory read port, and builds the result from the entry's page number and the bus address's page offset. An address that no enabled window claims is returned unchanged. Only one translation is in flight at a time. While a table read is outstanding, the request port is not ready.

Top module: `dma_window_xlate`

## Requirements
- R1: Window w matches when bus address bits 31:20 equal base bits 31:20 at every position where the window mask word has a 0 in bits 31:20. Mask bits set to 1 in 31:20 are don't-care positions, and bits 19:0 never take part in the compare.
- R2: A matching window is used only when bit 0 of its base word (enable) is 1. A matching window with that bit at 0 has no effect on the response.
- R3: When several enabled windows match, the one with the lowest index is used.
- R4: In direct mode (base bit 1 = 0), let K be the set made of mask bits 31:20 together with bits 19:0. The result takes the bus address at the positions in K and the translated base at every other position, bits 33:32 included.
- R5: In scatter-gather mode (base bit 1 = 1), the entry address is the translated base with bits 9:0 and the positions (mask bits 31:20 shifted right by 10) cleared, ORed with (bus address AND (mask bits 31:20 OR bits 19:13)) shifted right by 10. It is presented on `mrd_addr` with `mrd_valid`, and both are held until `mrd_ready` is seen high at a clock edge.
- R6: In scatter-gather mode, the result is the returned entry with bit 0 cleared and shifted left by 12, ORed with bus address bits 12:0.
- R7: Every result is 34 bits wide, and higher bits of the computed value are dropped.
- R8: When no enabled window matches, the result equals the bus address zero-extended, with `rsp_hit` = 0 and `rsp_sg` = 0.
- R9: For direct and miss cases, `rsp_valid` is high for one cycle, on the clock edge that follows the acceptance edge (`req_valid` and `req_ready` both high).
- R10: For scatter-gather, `req_ready` and `rsp_valid` stay low from acceptance until the response. `rsp_valid` rises on the edge after the edge at which `mrd_rsp_valid` is sampled high.
- R11: `rsp_hit` is 1 when a window was used, and `rsp_sg` is 1 when that window was in scatter-gather mode.
- R12: After reset, `req_ready` = 1, `rsp_valid` = 0 and `mrd_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | 32 | Bus address to translate |
| cfg_base | input | NUM_WIN*32 | Per-window base words; bit 0 enable, bit 1 scatter-gather |
| cfg_mask | input | NUM_WIN*32 | Per-window size masks; bits 31:20 used |
| cfg_tba | input | NUM_WIN*34 | Per-window translated base |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_addr | output | 34 | Translated DMA address |
| rsp_hit | output | 1 | A window was used |
| rsp_sg | output | 1 | The window used was in scatter-gather mode |
| mrd_valid | output | 1 | Page-table entry read request |
| mrd_ready | input | 1 | Memory accepts the read |
| mrd_addr | output | 34 | Entry address |
| mrd_rsp_valid | input | 1 | Entry data returned |
| mrd_rsp_data | input | 64 | Returned page-table entry |

## Verification
The bench builds the block with its default of four windows, the 32-bit bus address and the 34-bit result. Four windows are enough to create overlap chains, where one enabled match is shadowed by a lower index and a disabled lower window must be skipped to reach a higher one. The full 34-bit result lets translated bases with bits 33:32 set, and entries whose shifted page number overflows bit 33, show the truncation directly. Random memory stalls on both the read handshake and the data return exercise the hold and busy rules.

// File: rtl/dma_xlate_pkg.sv
package dma_xlate_pkg;
    localparam int BUS_W   = 32;
    localparam int DMA_W   = 34;
    localparam int PTE_W   = 64;
    localparam int CMP_LO  = 20;
    localparam int OFS_W   = 13;
    localparam logic [BUS_W-1:0] CMP_FIELD = 32'hFFF0_0000;

    typedef struct packed {
        logic             hit;
        logic             sg;
        logic [DMA_W-1:0] dir_addr;
        logic [DMA_W-1:0] pte_addr;
    } lane_t;

    typedef enum logic [1:0] {ST_IDLE, ST_MREQ, ST_MWAIT} xl_state_t;

    function automatic logic [DMA_W-1:0] widen(input logic [BUS_W-1:0] v);
        return {{(DMA_W-BUS_W){1'b0}}, v};
    endfunction

    function automatic logic [DMA_W-1:0] direct_xlate(input logic [BUS_W-1:0] bus,
                                                       input logic [BUS_W-1:0] msk,
                                                       input logic [DMA_W-1:0] tba);
        logic [DMA_W-1:0] keep;
        keep = widen((msk & CMP_FIELD) | ~CMP_FIELD);
        return (tba & ~keep) | (widen(bus) & keep);
    endfunction

    function automatic logic [DMA_W-1:0] entry_addr(input logic [BUS_W-1:0] bus,
                                                     input logic [BUS_W-1:0] msk,
                                                     input logic [DMA_W-1:0] tba);
        logic [DMA_W-1:0] tbl_keep;
        logic [BUS_W-1:0] idx_sel;
        tbl_keep = ~(widen((msk & CMP_FIELD) >> 10) | 34'h3FF);
        idx_sel  = (msk & CMP_FIELD) | (32'h7F << 13);
        return (tba & tbl_keep) | widen((bus & idx_sel) >> 10);
    endfunction

    function automatic logic [DMA_W-1:0] sg_xlate(input logic [PTE_W-1:0] ent,
                                                   input logic [OFS_W-1:0] ofs);
        return {ent[DMA_W-OFS_W:1], ofs};
    endfunction
endpackage

// File: rtl/dma_xlate_win.sv
module dma_xlate_win
    import dma_xlate_pkg::*;
(
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] base,
    input  logic [BUS_W-1:0] msk,
    input  logic [DMA_W-1:0] tba,
    output lane_t            lane
);
    logic [BUS_W-1:0] cmp;
    logic             match;
    logic             unused_cfg;

    assign cmp        = ~msk & CMP_FIELD;
    assign match      = ((bus_addr ^ base) & cmp) == '0;
    assign unused_cfg = ^{base[CMP_LO-1:2]};

    always_comb begin
        lane.hit      = match && base[0];
        lane.sg       = base[1];
        lane.dir_addr = direct_xlate(bus_addr, msk, tba);
        lane.pte_addr = entry_addr(bus_addr, msk, tba);
    end
endmodule

// File: rtl/dma_xlate_pick.sv
module dma_xlate_pick
    import dma_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  lane_t lanes [NUM_WIN],
    output lane_t win
);
    always_comb begin
        win = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (lanes[i].hit) win = lanes[i];
        end
    end
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
    import dma_xlate_pkg::*;
#(
    parameter int NUM_WIN = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [BUS_W-1:0]         req_addr,
    input  logic [NUM_WIN*BUS_W-1:0] cfg_base,
    input  logic [NUM_WIN*BUS_W-1:0] cfg_mask,
    input  logic [NUM_WIN*DMA_W-1:0] cfg_tba,
    output logic                     rsp_valid,
    output logic [DMA_W-1:0]         rsp_addr,
    output logic                     rsp_hit,
    output logic                     rsp_sg,
    output logic                     mrd_valid,
    input  logic                     mrd_ready,
    output logic [DMA_W-1:0]         mrd_addr,
    input  logic                     mrd_rsp_valid,
    input  logic [PTE_W-1:0]         mrd_rsp_data
);
    lane_t            lanes [NUM_WIN];
    lane_t            win;
    xl_state_t        state;
    logic [DMA_W-1:0] pte_q;
    logic [OFS_W-1:0] ofs_q;
    logic             accept;
    logic             unused_ent;

    assign unused_ent = ^{mrd_rsp_data[PTE_W-1:DMA_W-OFS_W+1], mrd_rsp_data[0]};

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        dma_xlate_win u_win (
            .bus_addr (req_addr),
            .base     (cfg_base[w*BUS_W +: BUS_W]),
            .msk      (cfg_mask[w*BUS_W +: BUS_W]),
            .tba      (cfg_tba[w*DMA_W +: DMA_W]),
            .lane     (lanes[w])
        );
    end

    dma_xlate_pick #(.NUM_WIN(NUM_WIN)) u_pick (
        .lanes (lanes),
        .win   (win)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign mrd_valid = (state == ST_MREQ);
    assign mrd_addr  = pte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_hit   <= 1'b0;
            rsp_sg    <= 1'b0;
            pte_q     <= '0;
            ofs_q     <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    if (win.hit && win.sg) begin
                        pte_q <= win.pte_addr;
                        ofs_q <= req_addr[OFS_W-1:0];
                        state <= ST_MREQ;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= win.hit;
                        rsp_sg    <= 1'b0;
                        rsp_addr  <= win.hit ? win.dir_addr : widen(req_addr);
                    end
                end
                ST_MREQ: if (mrd_ready) state <= ST_MWAIT;
                ST_MWAIT: if (mrd_rsp_valid) begin
                    rsp_valid <= 1'b1;
                    rsp_hit   <= 1'b1;
                    rsp_sg    <= 1'b1;
                    rsp_addr  <= sg_xlate(mrd_rsp_data, ofs_q);
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R10: no new request while a table read is pending
    p_busy_no_ready_r10: assert property (@(posedge clk) disable iff (rst)
        mrd_valid |-> !req_ready);

    // R5: read request held steady until taken
    p_mrd_hold_r5: assert property (@(posedge clk) disable iff (rst)
        mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr));

    // R9: direct or miss answers on the next edge
    p_fast_rsp_r9: assert property (@(posedge clk) disable iff (rst)
        accept && !(win.hit && win.sg) |=> rsp_valid);

    // R10: scatter-gather starts a read, no immediate answer
    p_sg_defer_r10: assert property (@(posedge clk) disable iff (rst)
        accept && win.hit && win.sg |=> !rsp_valid && mrd_valid);

    // R8: a miss is never flagged as scatter-gather
    p_miss_flags_r8: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_hit |-> !rsp_sg);

    // R10: after a scatter-gather answer the port is free again
    p_sg_release_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_sg |-> req_ready);
endmodule

// File: tb/dma_window_xlate_bench.sv
module dma_window_xlate_bench;
    localparam int NW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_hit, rsp_sg, mrd_valid;
    logic [33:0] rsp_addr, mrd_addr;
    logic        mrd_ready = 1'b0;
    logic        mrd_rsp_valid = 1'b0;
    logic [63:0] mrd_rsp_data = '0;

    logic [31:0] bw [NW];
    logic [31:0] mw [NW];
    logic [33:0] tw [NW];
    logic [NW*32-1:0] cfg_base, cfg_mask;
    logic [NW*34-1:0] cfg_tba;

    int vecs = 0;
    int bad  = 0;

    for (genvar g = 0; g < NW; g++) begin : g_cfg
        assign cfg_base[g*32 +: 32] = bw[g];
        assign cfg_mask[g*32 +: 32] = mw[g];
        assign cfg_tba[g*34 +: 34]  = tw[g];
    end

    always #2 clk = ~clk;

    dma_window_xlate #(.NUM_WIN(NW)) u_dma_window_xlate (
        .clk, .rst, .req_valid, .req_ready, .req_addr,
        .cfg_base, .cfg_mask, .cfg_tba,
        .rsp_valid, .rsp_addr, .rsp_hit, .rsp_sg,
        .mrd_valid, .mrd_ready, .mrd_addr, .mrd_rsp_valid, .mrd_rsp_data
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model: returns window index or -1
    function automatic int find_win(input logic [31:0] a);
        for (int w = 0; w < NW; w++) begin
            logic [31:0] care;
            care = ~mw[w] & 32'hFFF0_0000;
            if (((a & care) == (bw[w] & care)) && bw[w][0]) return w;
        end
        return -1;
    endfunction

    function automatic logic [33:0] exp_direct(input int w, input logic [31:0] a);
        logic [63:0] k, r;
        k = {32'h0, (mw[w] & 32'hFFF0_0000) | 32'h000F_FFFF};
        r = ({30'h0, tw[w]} & ~k) | ({32'h0, a} & k);
        return r[33:0];
    endfunction

    function automatic logic [33:0] exp_entry(input int w, input logic [31:0] a);
        logic [63:0] tm, bm, r;
        tm = ~(({32'h0, mw[w] & 32'hFFF0_0000} >> 10) | 64'h3FF);
        bm = {32'h0, mw[w] & 32'hFFF0_0000} | (64'h7F << 13);
        r  = ({30'h0, tw[w]} & tm) | (({32'h0, a} & bm) >> 10);
        return r[33:0];
    endfunction

    function automatic logic [33:0] exp_sg(input logic [63:0] e, input logic [31:0] a);
        logic [63:0] r;
        r = ((e & ~64'h1) << 12) | {51'h0, a[12:0]};
        return r[33:0];
    endfunction

    task automatic run(input logic [31:0] a, input string tag);
        int w;
        logic [63:0] ent;
        w = find_win(a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        if (w < 0 || !bw[w][1]) begin
            logic [33:0] e;
            e = (w < 0) ? {2'b00, a} : exp_direct(w, a);
            chk(rsp_valid === 1'b1, {"R9 ", tag, " rsp_valid"}, 64'(rsp_valid), 64'h1);
            chk(rsp_addr === e, (w < 0) ? {"R8 ", tag, " miss addr"} : {"R4 R7 ", tag, " direct addr"},
                64'(rsp_addr), 64'(e));
            chk(rsp_hit === (w >= 0) && rsp_sg === 1'b0, {"R11 ", tag, " flags"},
                64'({rsp_hit, rsp_sg}), 64'({w >= 0, 1'b0}));
        end else begin
            logic [33:0] pe;
            pe = exp_entry(w, a);
            chk(rsp_valid === 1'b0 && mrd_valid === 1'b1 && req_ready === 1'b0,
                {"R10 ", tag, " sg start"}, 64'({rsp_valid, mrd_valid, req_ready}), 64'b010);
            chk(mrd_addr === pe, {"R5 ", tag, " entry addr"}, 64'(mrd_addr), 64'(pe));
            repeat ($urandom_range(0, 2)) @(negedge clk);
            chk(mrd_valid === 1'b1 && mrd_addr === pe, {"R5 ", tag, " hold"}, 64'(mrd_addr), 64'(pe));
            mrd_ready = 1'b1;
            @(negedge clk);
            mrd_ready = 1'b0;
            repeat ($urandom_range(0, 3)) @(negedge clk);
            chk(req_ready === 1'b0 && mrd_valid === 1'b0 && rsp_valid === 1'b0,
                {"R10 ", tag, " wait"}, 64'({req_ready, mrd_valid, rsp_valid}), 64'b000);
            ent = {$urandom, $urandom};
            mrd_rsp_valid = 1'b1;
            mrd_rsp_data  = ent;
            @(negedge clk);
            mrd_rsp_valid = 1'b0;
            chk(rsp_valid === 1'b1 && rsp_hit === 1'b1 && rsp_sg === 1'b1,
                {"R10 R11 ", tag, " sg rsp"}, 64'({rsp_valid, rsp_hit, rsp_sg}), 64'b111);
            chk(rsp_addr === exp_sg(ent, a), {"R6 R7 ", tag, " sg addr"},
                64'(rsp_addr), 64'(exp_sg(ent, a)));
        end
    endtask

    task automatic rand_cfg();
        for (int w = 0; w < NW; w++) begin
            bw[w] = $urandom;
            mw[w] = $urandom & ($urandom | 32'h000F_FFFF);
            tw[w] = {$urandom_range(0, 3), $urandom};
        end
    endtask

    initial begin
        #400000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=0", 1);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int w = 0; w < NW; w++) begin
            bw[w] = '0; mw[w] = '0; tw[w] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready === 1'b1 && rsp_valid === 1'b0 && mrd_valid === 1'b0,
            "R12 reset", 64'({req_ready, rsp_valid, mrd_valid}), 64'b100);

        // All windows off: pass-through
        run(32'hDEAD_BEEF, "all off");

        // R1: masked compare, window 2 direct, 256 MiB span
        bw[2] = 32'h4000_0001; mw[2] = 32'h0FF0_0000; tw[2] = 34'h3_8000_0000;
        run(32'h4ABC_1234, "R1 R4 in span");
        run(32'h5ABC_1234, "R1 out of span");

        // R2: disabled window 0 covering same span is skipped
        bw[0] = 32'h4000_0000; mw[0] = 32'h0FF0_0000; tw[0] = 34'h0_1000_0000;
        run(32'h4001_0000, "R2 disabled skip");

        // R3: enabled window 1 and window 2 both match; 1 wins
        bw[1] = 32'h4000_0003; mw[1] = 32'hFFF0_0000; tw[1] = 34'h2_0000_0000;
        run(32'h4123_4567, "R3 priority sg");
        bw[1] = 32'h4000_0001;
        run(32'h4123_4567, "R3 priority direct");

        // R7: entry overflowing bit 33 after shift
        bw[1] = 32'h4000_0003; mw[1] = 32'h0000_0000; tw[1] = 34'h3_FFFF_FFFF;
        run(32'h400F_FFFF, "R7 sg trunc");

        // Random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a;
            int w;
            if (i % 25 == 0) rand_cfg();
            w = $urandom_range(0, NW - 1);
            a = ($urandom_range(0, 3) == 0) ? $urandom
                : ((bw[w] & 32'hFFF0_0000) ^ ($urandom & (mw[w] | 32'h000F_FFFF)));
            run(a, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule